// File: doc/BRIEF.md
# Framed SPI Master Controller

This block is a memory-mapped SPI master on a simple 32-bit register bus with single-cycle writes and reads that need no wait states. Software selects a clock mode, a word length and a bit rate. It then writes one word into the transmit buffer, which starts a shift at once, and reads the word that came back from the receive buffer. The controller holds exactly one word in each direction.

Every transmitted word carries two tags, a chip-select channel and an end-of-frame marker. The chosen active-low chip select is driven low a half bit-period before the first clock edge. It stays low across a run of untagged words and is released only after the last edge of a word tagged end-of-frame, so software can build multi-word frames one word at a time. The receive side reports the channel and tag of the word that produced the current receive data. Sticky event flags, together with a mask, drive a single interrupt line.

Top module: `spi_frame_master`

## Requirements
- R1: After reset all chip selects are high, SCLK is low, irq is low, the busy bit reads 0, interrupt status reads 0x08 (transmit side empty, nothing received, no events) and the interrupt mask reads 0.
- R2: The settings registers read back what was written: mode at 0x40 (bit 31 enable, bit 14 clock polarity, bit 13 clock phase, bit 12 loopback, bit 11 master, bits [1:0] length code), rate at 0x48 bits [2:0], word tag at 0x4C (bits [1:0] channel, bit 2 end-of-frame) and interrupt mask at 0x6C bits [7:4].
- R3: A write to 0x50 while enabled, in master mode and idle starts a shift of 8*(code+1) bits taken from the low bits of the written data, most significant bit first. A write to 0x50 at any other time starts nothing.
- R4: With rate value N in 1..7 one SCLK period lasts 2^N bus clocks, so each SCLK level lasts 2^(N-1) clocks. A value of 0 behaves like 1.
- R5: SCLK rests at the polarity bit while idle. With phase 0 data is sampled on the leading edge and changed on the trailing edge. With phase 1 it is changed on the leading edge and sampled on the trailing edge.
- R6: In loopback the receiver takes the MOSI stream and ignores MISO, so the received word equals the sent word masked to the length.
- R7: At most one chip select is low. The tagged channel goes low before the first SCLK edge, stays low after an untagged word and goes high after the word tagged end-of-frame.
- R8: The receive buffer at 0x58 holds the received bits zero-extended to 32 bits. The receive tag at 0x54 (bits [1:0] channel, bit 2 end-of-frame) equals the tag of that word.
- R9: Bit 0 of 0x44 reads 1 while a word is in progress. Bit 3 of 0x68 reads 1 when a new word may be written. Bit 2 of 0x68 is set when a word completes and cleared by reading 0x58.
- R10: Bits [7:4] of 0x68 are sticky events: bit 4 word done, bit 5 end-of-frame word done, bit 6 word completed while the receive buffer was still full, bit 7 transmit write refused. Writing ones to them clears them.
- R11: irq is high exactly when some sticky event bit is set and its mask bit in 0x6C [7:4] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, data valid in the same cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| irq | output | 1 | Masked OR of the sticky events |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects, one per channel |

## Verification
The bench uses the default parameters: four chip selects, a 32-bit data path and a 3-bit rate field. This brings every length code from 8 to 32 bits and all four clock modes into reach at rates 1 and 2, and a pin-level slave model checks both shift directions. Rate 3 and rate 0 are measured directly at SCLK. Directed sequences cover a two-word frame on one channel, an overrun, a refused write while disabled, and the interrupt mask.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NUM_CS = 4;
  localparam int unsigned CH_W   = $clog2(NUM_CS);
  localparam int unsigned RATE_W = 3;
  localparam int unsigned CNT_W  = 7;
  localparam int unsigned EV_W   = 4;
  localparam int unsigned EDGE_W = 6;

  localparam logic [ADDR_W-1:0] OFF_MODE = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_BUSY = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_RATE = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_TTAG = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_TDAT = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_RTAG = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_RDAT = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_EVT  = 8'h68;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h6C;

  typedef struct packed {
    logic       en;
    logic       cpol;
    logic       cpha;
    logic       loop;
    logic       master;
    logic [1:0] len;
  } mode_t;

  typedef struct packed {
    logic            eof;
    logic [CH_W-1:0] chan;
  } tag_t;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LEAD,
    SH_RUN,
    SH_TAIL
  } sh_state_t;
endpackage

// File: rtl/spi_fm_tick.sv
module spi_fm_tick
  import spi_fm_pkg::*;
#(
  parameter int unsigned RW = RATE_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    if (rate == '0) lim = '0;
    else            lim = (CW'(1) << (rate - RW'(1))) - CW'(1);
  end

  assign tick = run && (cnt_q == lim);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_fm_shift.sv
module spi_fm_shift
  import spi_fm_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NCS = NUM_CS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  tag_t          tx_tag,
  input  mode_t         mode,
  input  logic          tick,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic [NCS-1:0] cs_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output tag_t          rx_tag
);
  sh_state_t       st_q, st_d;
  logic [DW-1:0]   tsh_q, tsh_d, rsh_q, rsh_d;
  logic [EDGE_W-1:0] edg_q, edg_d;
  logic            lvl_q, lvl_d, cs_on_q, cs_on_d;
  tag_t            tag_q, tag_d;
  logic            cpol_q, cpha_q, loop_q;
  logic [1:0]      len_q;
  logic            lead, last, din;

  assign lead = !edg_q[0];
  assign last = (edg_q == {len_q, 4'b1111});
  assign din  = loop_q ? mosi : miso;
  assign busy = (st_q != SH_IDLE);
  assign done = (st_q == SH_TAIL) && tick;

  always_comb begin
    st_d    = st_q;
    tsh_d   = tsh_q;
    rsh_d   = rsh_q;
    edg_d   = edg_q;
    lvl_d   = lvl_q;
    cs_on_d = cs_on_q;
    tag_d   = tag_q;
    unique case (st_q)
      SH_IDLE: if (start) begin
        tsh_d   = tx_word << {~mode.len, 3'b000};
        rsh_d   = '0;
        edg_d   = '0;
        lvl_d   = 1'b0;
        tag_d   = tx_tag;
        cs_on_d = 1'b1;
        st_d    = SH_LEAD;
      end
      SH_LEAD: if (tick) st_d = SH_RUN;
      SH_RUN: if (tick) begin
        lvl_d = !lvl_q;
        if (lead ^ cpha_q) rsh_d = {rsh_q[DW-2:0], din};
        if (cpha_q ? (lead && (edg_q != '0)) : (!lead && !last))
          tsh_d = tsh_q << 1;
        if (last) st_d = SH_TAIL;
        else      edg_d = edg_q + EDGE_W'(1);
      end
      SH_TAIL: if (tick) begin
        st_d = SH_IDLE;
        if (tag_q.eof) cs_on_d = 1'b0;
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SH_IDLE;
      tsh_q   <= '0;
      rsh_q   <= '0;
      edg_q   <= '0;
      lvl_q   <= 1'b0;
      cs_on_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      st_q    <= st_d;
      tsh_q   <= tsh_d;
      rsh_q   <= rsh_d;
      edg_q   <= edg_d;
      lvl_q   <= lvl_d;
      cs_on_q <= cs_on_d;
      tag_q   <= tag_d;
    end
  end

  // word settings are frozen for the duration of a word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      loop_q <= 1'b0;
      len_q  <= '0;
    end else if (start && !busy) begin
      cpol_q <= mode.cpol;
      cpha_q <= mode.cpha;
      loop_q <= mode.loop;
      len_q  <= mode.len;
    end
  end

  assign sclk    = busy ? (cpol_q ^ lvl_q) : mode.cpol;
  assign mosi    = tsh_q[DW-1];
  assign rx_word = rsh_q;
  assign rx_tag  = tag_q;

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign cs_n[k] = !(cs_on_q && (tag_q.chan == k));
  end
endmodule

// File: rtl/spi_fm_regs.sv
module spi_fm_regs
  import spi_fm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_word,
  input  tag_t          rx_tag,
  output logic [DW-1:0] rdata,
  output mode_t         mode,
  output logic [RATE_W-1:0] rate,
  output tag_t          tx_tag,
  output logic          start,
  output logic          rx_full,
  output logic [EV_W-1:0] ien,
  output logic          irq
);
  mode_t           mode_d;
  logic [RATE_W-1:0] rate_d;
  tag_t            ttag_d, rtag_q, rtag_d;
  logic [DW-1:0]   rbuf_q, rbuf_d;
  logic            rx_full_d;
  logic [EV_W-1:0] ev_q, ev_d, ev_set, ien_d;
  logic            wr_tdat;

  assign wr_tdat = wr && (addr == OFF_TDAT);
  assign start   = wr_tdat && mode.en && mode.master && !busy;
  assign ev_set  = {wr_tdat && !start, done && rx_full, done && rx_tag.eof, done};

  always_comb begin
    mode_d    = mode;
    rate_d    = rate;
    ttag_d    = tx_tag;
    ien_d     = ien;
    rtag_d    = rtag_q;
    rbuf_d    = rbuf_q;
    rx_full_d = rx_full;
    ev_d      = ev_q;
    if (wr) begin
      unique case (addr)
        OFF_MODE: mode_d = '{en: wdata[31], cpol: wdata[14], cpha: wdata[13],
                             loop: wdata[12], master: wdata[11], len: wdata[1:0]};
        OFF_RATE: rate_d = wdata[RATE_W-1:0];
        OFF_TTAG: ttag_d = wdata[CH_W:0];
        OFF_MASK: ien_d  = wdata[7:4];
        OFF_EVT:  ev_d   = ev_q & ~wdata[7:4];
        default: ;
      endcase
    end
    if (rd && (addr == OFF_RDAT)) rx_full_d = 1'b0;
    if (done) begin
      rbuf_d    = rx_word;
      rtag_d    = rx_tag;
      rx_full_d = 1'b1;
    end
    ev_d = ev_d | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      rate    <= '0;
      tx_tag  <= '0;
      ien     <= '0;
      rtag_q  <= '0;
      rbuf_q  <= '0;
      rx_full <= 1'b0;
      ev_q    <= '0;
    end else begin
      mode    <= mode_d;
      rate    <= rate_d;
      tx_tag  <= ttag_d;
      ien     <= ien_d;
      rtag_q  <= rtag_d;
      rbuf_q  <= rbuf_d;
      rx_full <= rx_full_d;
      ev_q    <= ev_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        OFF_MODE: begin
          rdata[31] = mode.en;
          rdata[14] = mode.cpol;
          rdata[13] = mode.cpha;
          rdata[12] = mode.loop;
          rdata[11] = mode.master;
          rdata[1:0] = mode.len;
        end
        OFF_BUSY: rdata[0] = busy;
        OFF_RATE: rdata[RATE_W-1:0] = rate;
        OFF_TTAG: rdata[CH_W:0] = tx_tag;
        OFF_RTAG: rdata[CH_W:0] = rtag_q;
        OFF_RDAT: rdata = rbuf_q;
        OFF_EVT:  rdata[7:0] = {ev_q, !busy, rx_full, 2'b00};
        OFF_MASK: rdata[7:4] = ien;
        default: ;
      endcase
    end
  end

  assign irq = |(ev_q & ien);
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  mode_t             mode;
  logic [RATE_W-1:0] rate;
  tag_t              tx_tag, rx_tag;
  logic              start, busy, done, tick, rx_full;
  logic [DATA_W-1:0] rx_word;
  logic [EV_W-1:0]   ien;
  logic              cfg_cpol;

  assign cfg_cpol = mode.cpol;

  spi_fm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .busy(busy), .done(done), .rx_word(rx_word),
    .rx_tag(rx_tag), .rdata(bus_rdata), .mode(mode), .rate(rate),
    .tx_tag(tx_tag), .start(start), .rx_full(rx_full), .ien(ien), .irq(irq)
  );

  spi_fm_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate), .tick(tick)
  );

  spi_fm_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(bus_wdata),
    .tx_tag(tx_tag), .mode(mode), .tick(tick), .miso(miso), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done), .rx_word(rx_word),
    .rx_tag(rx_tag)
  );
endmodule

// File: rtl/spi_fm_chk.sv
module spi_fm_chk
  import spi_fm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sclk,
  input logic              irq,
  input logic              busy,
  input logic              rx_full,
  input logic [EV_W-1:0]   ien,
  input logic              cfg_cpol
);
  // R7
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n) |-> $fell(busy));

  // R9
  rx_full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $fell(busy));

  // R5
  sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cfg_cpol)) |-> $stable(sclk));

  // R5
  sclk_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_cpol));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

bind spi_frame_master spi_fm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .irq(irq),
  .busy(busy), .rx_full(rx_full), .ien(ien), .cfg_cpol(cfg_cpol)
);

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, sclk, mosi, miso;
  logic [3:0] cs_n;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic m_cpol = 0, m_cpha = 0;
  logic [31:0] s_out = '0, s_cap = '0;
  bit s_first = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_master uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // pin-level slave model, following the clock mode rules of R5
  assign miso = s_out[31];
  always @(sclk) begin
    if (cs_n != 4'hF) begin
      if ((sclk != m_cpol) ^ m_cpha) s_cap = {s_cap[30:0], mosi};
      else if (m_cpha ? ((sclk != m_cpol) && !s_first) : (sclk == m_cpol))
        s_out = s_out << 1;
      if (sclk != m_cpol) s_first = 0;
    end
  end

  function automatic logic [31:0] len_mask(input logic [1:0] len);
    return (len == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (len + 1))) - 1);
  endfunction

  function automatic logic [31:0] mode_word(input bit en, input bit lp,
      input bit cpha, input bit cpol, input logic [1:0] len);
    return {en, 16'h0, cpol, cpha, lp, 1'b1, 9'h0, len};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_mode(input bit lp, input bit cpha, input bit cpol,
                          input logic [1:0] len);
    m_cpol = cpol; m_cpha = cpha;
    wr32(8'h40, mode_word(1'b1, lp, cpha, cpol, len));
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd32(8'h44, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic send(input logic [1:0] ch, input bit eof, input logic [31:0] d,
                      input logic [31:0] sw, input logic [1:0] len);
    wr32(8'h4C, {29'h0, eof, ch});
    s_out = sw << (8 * (3 - len)); s_cap = '0; s_first = 1;
    wr32(8'h50, d);
  endtask

  task automatic word_check(input logic [1:0] ch, input bit eof, input bit lp,
      input logic [31:0] d, input logic [31:0] sw, input logic [1:0] len);
    logic [31:0] v;
    rd32(8'h54, v);
    chk("R8 rx tag", v, {29'h0, eof, ch});
    rd32(8'h58, v);
    chk(lp ? "R6 loopback data" : "R5 received data", v,
        (lp ? d : sw) & len_mask(len));
    if (!lp) chk("R3 slave captured data", s_cap, d & len_mask(len));
  endtask

  task automatic half_period(input logic [2:0] rate, input int exp);
    int t0, t1, n;
    logic prev;
    wr32(8'h48, {29'h0, rate});
    set_mode(1'b1, 1'b0, 1'b0, 2'd0);
    send(2'd0, 1'b1, 32'h5A, 32'h0, 2'd0);
    prev = sclk; t0 = -1; t1 = -1; n = 0;
    while (t1 < 0 && n < 2000) begin
      @(negedge clk); n++;
      if (sclk != prev) begin
        if (t0 < 0) t0 = n; else t1 = n;
        prev = sclk;
      end
    end
    chk("R4 sclk half period", 32'(t1 - t0), 32'(exp));
    wait_idle();
    rd32(8'h58, bus_wdata_dummy);
  endtask

  logic [31:0] bus_wdata_dummy;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d, sw;
    logic [1:0] len, ch;
    bit lp, cph, cpl;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", {28'h0, cs_n}, 32'hF);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd32(8'h44, v); chk("R1 busy", v, 32'h0);
    rd32(8'h68, v); chk("R1 event status", v, 32'h8);
    rd32(8'h6C, v); chk("R1 mask", v, 32'h0);

    // R2 readback
    wr32(8'h40, mode_word(1'b1, 1'b1, 1'b0, 1'b1, 2'd2));
    rd32(8'h40, v); chk("R2 mode", v, mode_word(1'b1, 1'b1, 1'b0, 1'b1, 2'd2));
    wr32(8'h48, 32'h5); rd32(8'h48, v); chk("R2 rate", v, 32'h5);
    wr32(8'h4C, 32'h6); rd32(8'h4C, v); chk("R2 tag", v, 32'h6);
    wr32(8'h6C, 32'hA0); rd32(8'h6C, v); chk("R2 mask", v, 32'hA0);
    wr32(8'h6C, 32'h0);
    m_cpol = 1'b1; m_cpha = 1'b0;
    @(negedge clk); chk("R5 idle level", {31'h0, sclk}, 32'h1);

    // R4 bit rate
    half_period(3'd3, 4);
    half_period(3'd1, 1);
    half_period(3'd0, 1);

    // R3 R5 R6 R8 random words
    wr32(8'h68, 32'hF0);
    for (int i = 0; i < 24; i++) begin
      len = 2'($urandom_range(0, 3)); ch = 2'($urandom_range(0, 3));
      lp = 1'($urandom_range(0, 1)); cph = 1'($urandom_range(0, 1));
      cpl = 1'($urandom_range(0, 1));
      d = $urandom(); sw = $urandom();
      wr32(8'h48, 32'($urandom_range(1, 2)));
      set_mode(lp, cph, cpl, len);
      send(ch, 1'b1, d, sw, len);
      rd32(8'h44, v); chk("R9 busy during word", v, 32'h1);
      wait_idle();
      rd32(8'h68, v); chk("R9 rx full and tx empty", {28'h0, v[3:0]}, 32'hC);
      word_check(ch, 1'b1, lp, d, sw, len);
      rd32(8'h68, v); chk("R9 rx full cleared by read", {31'h0, v[2]}, 32'h0);
      chk("R7 released after tagged word", {28'h0, cs_n}, 32'hF);
      chk("R5 sclk rest", {31'h0, sclk}, {31'h0, cpl});
    end

    // R8 zero extension
    set_mode(1'b1, 1'b0, 1'b0, 2'd0);
    send(2'd1, 1'b1, 32'hFFFF_FFFF, 32'h0, 2'd0);
    wait_idle();
    rd32(8'h58, v); chk("R8 zero extended", v, 32'hFF);

    // R7 R10 two-word frame on channel 2, slave model, mode 3
    wr32(8'h68, 32'hF0);
    set_mode(1'b0, 1'b1, 1'b1, 2'd1);
    send(2'd2, 1'b0, 32'h1234, 32'hBEEF, 2'd1);
    chk("R7 select asserted", {28'h0, cs_n}, 32'hB);
    wait_idle();
    chk("R7 held after untagged word", {28'h0, cs_n}, 32'hB);
    rd32(8'h68, v); chk("R10 word done only", {28'h0, v[7:4]}, 32'h1);
    word_check(2'd2, 1'b0, 1'b0, 32'h1234, 32'hBEEF, 2'd1);
    send(2'd2, 1'b1, 32'hC3A5, 32'h7E81, 2'd1);
    wait_idle();
    chk("R7 released after frame", {28'h0, cs_n}, 32'hF);
    rd32(8'h68, v); chk("R10 frame done", {28'h0, v[7:4]}, 32'h3);
    word_check(2'd2, 1'b1, 1'b0, 32'hC3A5, 32'h7E81, 2'd1);

    // R11 mask and clear
    chk("R11 masked", {31'h0, irq}, 32'h0);
    wr32(8'h6C, 32'h20);
    @(negedge clk); chk("R11 enabled event", {31'h0, irq}, 32'h1);
    wr32(8'h68, 32'hF0);
    @(negedge clk); chk("R11 cleared", {31'h0, irq}, 32'h0);
    rd32(8'h68, v); chk("R10 cleared by ones", {28'h0, v[7:4]}, 32'h0);

    // R10 overrun
    set_mode(1'b1, 1'b0, 1'b0, 2'd0);
    send(2'd0, 1'b1, 32'h11, 32'h0, 2'd0); wait_idle();
    send(2'd3, 1'b1, 32'h22, 32'h0, 2'd0); wait_idle();
    rd32(8'h68, v); chk("R10 overrun", {31'h0, v[6]}, 32'h1);
    rd32(8'h58, v); chk("R8 newest word kept", v, 32'h22);
    rd32(8'h54, v); chk("R8 newest tag kept", v, 32'h7);

    // R3 R10 refused write while disabled
    wr32(8'h68, 32'hF0);
    wr32(8'h40, mode_word(1'b0, 1'b1, 1'b0, 1'b0, 2'd0));
    wr32(8'h50, 32'h99);
    chk("R3 no select when disabled", {28'h0, cs_n}, 32'hF);
    rd32(8'h44, v); chk("R3 no shift when disabled", v, 32'h0);
    rd32(8'h68, v); chk("R10 refused write", {28'h0, v[7:4]}, 32'h8);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule